// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block places a direct-mapped data cache between a requester that issues single-word reads and writes and a slower memory that moves whole blocks. Every request address is cut into a word offset, a line index and a tag. A read that finds its line valid with a matching tag returns data in the same cycle without stalling. Any other access holds the requester stalled while the controller runs a short sequence on the memory port. That sequence optionally writes back the old line, fetches the new block, optionally writes the updated line through to memory, and then completes the access.

A parameter selects the write policy. In write-back mode the cache keeps a dirty flag per line and writes to memory only when a modified line is displaced. In write-through mode there is no dirty state and every write also sends the updated line to memory. Writes that miss allocate the line in both modes. The line count, the block size in words, the word width and the address width are all parameters. The memory side uses a request/acknowledge handshake, so it may take any number of cycles to answer.

Top module: `dm_cache_ctrl`

## Requirements
- R1: A byte address splits into the byte offset (lowest log2(WORD_W/8) bits, ignored), then the word offset (next log2(WORDS) bits), then the line index (next log2(LINES) bits), with the tag in the remaining upper bits. Two addresses with equal index and different tags share one line. Blocks with distinct indices stay resident together.
- R2: Reset clears every valid and dirty flag. The first access to any line after reset misses and issues no write-back. With no request pending, cpu_stall and mem_req are low.
- R3: A read that hits returns the addressed word on cpu_rdata in the cycle of the request, with cpu_stall low.
- R4: On a miss, cpu_stall is high from the cycle the miss is seen until the cycle the result is delivered. With a memory that acknowledges L cycles after it first samples a request, a miss with no write-back takes 3+L stalled cycles and a miss that writes back a victim takes 5+2L. mem_req, mem_we and mem_addr stay constant from the raising of mem_req until mem_ack.
- R5: A read miss fetches the whole block with one memory read at block address cpu_addr >> log2(block bytes), returns the addressed word, and makes the other words of that block hit.
- R6: In write-back mode a write hit updates only the cached word, marks the line dirty, completes without a stall and starts no memory transaction.
- R7: In write-back mode, replacing a valid dirty line first writes that line to its own block address, then fetches the new block. Replacing a clean line issues no write.
- R8: A write miss fetches the block, merges the written word into it, and leaves the rest of the block as read from memory. In write-back mode it issues no memory write.
- R9: In write-through mode every write issues exactly one memory block write that holds the updated word. A write hit stalls 3+L cycles and a write miss 5+2L. Replacing a line never causes a write.
- R10: Results are correct for any memory response delay. Memory latencies 0 to 3 give identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held with its fields while cpu_stall is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | WORD_W | Write data |
| cpu_rdata | output | WORD_W | Read data, valid when cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Block transaction request, held until mem_ack |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W-log2(WORD_W/8)-log2(WORDS) | Block address |
| mem_wdata | output | WORDS*WORD_W | Block write data, word 0 in the low bits |
| mem_rdata | input | WORDS*WORD_W | Block read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current block transaction |

## Verification
The bench builds two copies side by side with 12-bit addresses, 32-bit words, 8 lines of 4 words: one in write-back mode and one in write-through mode. Both copies receive the same accesses, and each has its own behavioural memory. With only 5 tag bits and 32 word slots in the cache, the sweep writes and reads every word of every line under four tags at each memory latency from 0 to 3. This exercises every dirty eviction and every write-through transaction. Directed accesses at a fixed latency pin down the exact stall lengths and memory write counts.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WBACK   = 3'd1,
      ST_REFILL  = 3'd2,
      ST_WTHRU   = 3'd3,
      ST_RESPOND = 3'd4
   } dmc_state_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int ADDR_W = 12,
   parameter int BO_W   = 2,
   parameter int WO_W   = 2,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [IDX_W-1:0]  idx,
   output logic [WO_W-1:0]   woff
);

   // byte lanes within a word do not take part in the lookup
   logic unused_byte_bits;
   assign unused_byte_bits = ^addr[BO_W-1:0];

   assign woff = addr[BO_W +: WO_W];
   assign idx  = addr[BO_W+WO_W +: IDX_W];
   assign tag  = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
   parameter int LINES       = 8,
   parameter int WORDS       = 4,
   parameter int WORD_W      = 32,
   parameter int TAG_W       = 5,
   parameter int IDX_W       = 3,
   parameter int WO_W        = 2,
   parameter bit TRACK_DIRTY = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IDX_W-1:0]          idx,
   output logic                      rd_valid,
   output logic                      rd_dirty,
   output logic [TAG_W-1:0]          rd_tag,
   output logic [WORDS*WORD_W-1:0]   rd_line,
   input  logic                      word_we,
   input  logic [WO_W-1:0]           woff,
   input  logic [WORD_W-1:0]         wdata,
   input  logic                      fill_we,
   input  logic [TAG_W-1:0]          fill_tag,
   input  logic [WORDS*WORD_W-1:0]   fill_line,
   input  logic                      fill_dirty
);

   localparam int LINE_W = WORDS * WORD_W;

   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (fill_we) begin
         valid_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) begin
         tag_q[idx]  <= fill_tag;
         data_q[idx] <= fill_line;
      end else if (word_we) begin
         data_q[idx][woff*WORD_W +: WORD_W] <= wdata;
      end
   end

   assign rd_valid = valid_q[idx];
   assign rd_tag   = tag_q[idx];
   assign rd_line  = data_q[idx];

   generate
      if (TRACK_DIRTY) begin : g_dirty
         logic [LINES-1:0] dirty_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dirty_q <= '0;
            end else if (fill_we) begin
               dirty_q[idx] <= fill_dirty;
            end else if (word_we) begin
               dirty_q[idx] <= 1'b1;
            end
         end
         assign rd_dirty = dirty_q[idx];
      end else begin : g_clean
         logic unused_fill_dirty;
         assign unused_fill_dirty = fill_dirty;
         assign rd_dirty = 1'b0;
      end
   endgenerate

   // R8
   fill_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_we && word_we));

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_req,
   input  logic       cpu_we,
   input  logic       hit,
   input  logic       victim_valid,
   input  logic       victim_dirty,
   input  logic       mem_ack,
   output dmc_state_e state,
   output logic       cpu_stall,
   output logic       mem_req,
   output logic       mem_we,
   output logic       sel_victim,
   output logic       word_we,
   output logic       fill_we,
   output logic       fill_dirty
);

   dmc_state_e state_q, state_d;
   logic       wt_write;
   logic       evict_dirty;
   logic       hit_done;

   generate
      if (WRITE_BACK) begin : g_wback
         assign wt_write    = 1'b0;
         assign evict_dirty = victim_valid && victim_dirty;
      end else begin : g_wthru
         logic unused_victim;
         assign unused_victim = victim_valid ^ victim_dirty;
         assign wt_write      = cpu_we;
         assign evict_dirty   = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (hit) begin
                  if (wt_write) state_d = ST_WTHRU;
               end else if (evict_dirty) begin
                  state_d = ST_WBACK;
               end else begin
                  state_d = ST_REFILL;
               end
            end
         end
         ST_WBACK:  if (mem_ack) state_d = ST_REFILL;
         ST_REFILL: if (mem_ack) state_d = wt_write ? ST_WTHRU : ST_RESPOND;
         ST_WTHRU:  if (mem_ack) state_d = ST_RESPOND;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign hit_done   = (state_q == ST_IDLE) && hit && !wt_write;
   assign cpu_stall  = cpu_req && !hit_done && (state_q != ST_RESPOND);
   assign mem_req    = (state_q == ST_WBACK) || (state_q == ST_REFILL) || (state_q == ST_WTHRU);
   assign mem_we     = (state_q == ST_WBACK) || (state_q == ST_WTHRU);
   assign sel_victim = (state_q == ST_WBACK);
   assign word_we    = (state_q == ST_IDLE) && cpu_req && cpu_we && hit;
   assign fill_we    = (state_q == ST_REFILL) && mem_ack;
   assign fill_dirty = cpu_we;
   assign state      = state_q;

endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
   import dmc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int WORD_W     = 32,
   parameter int LINES      = 8,
   parameter int WORDS      = 4,
   parameter bit WRITE_BACK = 1'b1,
   localparam int BO_W      = $clog2(WORD_W / 8),
   localparam int WO_W      = $clog2(WORDS),
   localparam int IDX_W     = $clog2(LINES),
   localparam int TAG_W     = ADDR_W - BO_W - WO_W - IDX_W,
   localparam int BA_W      = TAG_W + IDX_W,
   localparam int LINE_W    = WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [BA_W-1:0]   mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   initial begin : param_chk
      assert (WORD_W >= 16 && (WORD_W % 8) == 0 && (1 << BO_W) == WORD_W / 8)
         else $fatal(1, "WORD_W must be a power-of-two byte count of at least 2");
      assert (WORDS >= 2 && (1 << WO_W) == WORDS)
         else $fatal(1, "WORDS must be a power of two, at least 2");
      assert (LINES >= 2 && (1 << IDX_W) == LINES)
         else $fatal(1, "LINES must be a power of two, at least 2");
      assert (TAG_W >= 1)
         else $fatal(1, "ADDR_W leaves no tag bits");
   end

   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  idx;
   logic [WO_W-1:0]   woff;
   logic              victim_valid, victim_dirty;
   logic [TAG_W-1:0]  victim_tag;
   logic [LINE_W-1:0] rd_line;
   logic [LINE_W-1:0] fill_line;
   logic              hit;
   logic              word_we, fill_we, fill_dirty, sel_victim;
   dmc_state_e        state;
   logic [WORD_W-1:0] line_words [WORDS];

   dmc_addr_split #(
      .ADDR_W(ADDR_W), .BO_W(BO_W), .WO_W(WO_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_split (
      .addr (cpu_addr),
      .tag  (req_tag),
      .idx  (idx),
      .woff (woff)
   );

   dmc_store #(
      .LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W),
      .IDX_W(IDX_W), .WO_W(WO_W), .TRACK_DIRTY(WRITE_BACK)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (idx),
      .rd_valid   (victim_valid),
      .rd_dirty   (victim_dirty),
      .rd_tag     (victim_tag),
      .rd_line    (rd_line),
      .word_we    (word_we),
      .woff       (woff),
      .wdata      (cpu_wdata),
      .fill_we    (fill_we),
      .fill_tag   (req_tag),
      .fill_line  (fill_line),
      .fill_dirty (fill_dirty)
   );

   assign hit = victim_valid && (victim_tag == req_tag);

   dmc_ctrl #(
      .WRITE_BACK(WRITE_BACK)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .cpu_we       (cpu_we),
      .hit          (hit),
      .victim_valid (victim_valid),
      .victim_dirty (victim_dirty),
      .mem_ack      (mem_ack),
      .state        (state),
      .cpu_stall    (cpu_stall),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .sel_victim   (sel_victim),
      .word_we      (word_we),
      .fill_we      (fill_we),
      .fill_dirty   (fill_dirty)
   );

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         assign line_words[w] = rd_line[w*WORD_W +: WORD_W];
         assign fill_line[w*WORD_W +: WORD_W] =
            (cpu_we && (woff == WO_W'(w))) ? cpu_wdata : mem_rdata[w*WORD_W +: WORD_W];
      end
   endgenerate

   assign cpu_rdata = line_words[woff];
   assign mem_addr  = {(sel_victim ? victim_tag : req_tag), idx};
   assign mem_wdata = rd_line;

   // R4
   mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R5
   fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REFILL && mem_ack) |=> hit);

   // R4
   respond_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RESPOND) |-> hit);

   generate
      if (WRITE_BACK) begin : g_wb_chk
         // R7
         wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_WBACK) |-> (victim_valid && victim_dirty));
         // R6
         hit_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_IDLE && cpu_req && cpu_we && hit) |=> !mem_req);
      end else begin : g_wt_chk
         // R9
         wt_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_WTHRU) |-> (line_words[woff] == cpu_wdata));
      end
   endgenerate

endmodule

// File: tb/dm_cache_ctrl_bench.sv
module dmc_bench_mem #(
   parameter int BA_W   = 8,
   parameter int WORDS  = 4,
   parameter int WORD_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  int                      lat,
   input  logic                    req,
   input  logic                    we,
   input  logic [BA_W-1:0]         addr,
   input  logic [WORDS*WORD_W-1:0] wdata,
   output logic [WORDS*WORD_W-1:0] rdata,
   output logic                    ack,
   output int                      wr_cnt,
   output int                      rd_cnt
);
   logic [WORDS*WORD_W-1:0] mem [1 << BA_W];
   int cnt;

   function automatic logic [WORD_W-1:0] seed_word(int i);
      return WORD_W'(i) * WORD_W'(32'h0001_0101) + WORD_W'(32'h5A00_0000);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < (1 << BA_W); b++)
            for (int w = 0; w < WORDS; w++)
               mem[b][w*WORD_W +: WORD_W] <= seed_word(b * WORDS + w);
         ack <= 1'b0; cnt <= 0; wr_cnt <= 0; rd_cnt <= 0; rdata <= '0;
      end else if (ack) begin
         ack <= 1'b0;
      end else if (req) begin
         if (cnt >= lat) begin
            ack <= 1'b1;
            cnt <= 0;
            if (we) begin
               mem[addr] <= wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               rdata <= mem[addr];
               rd_cnt <= rd_cnt + 1;
            end
         end else begin
            cnt <= cnt + 1;
         end
      end
   end
endmodule

module dm_cache_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 12;
   localparam int WORD_W = 32;
   localparam int LINES  = 8;
   localparam int WORDS  = 4;
   localparam int BA_W   = 8;
   localparam int LINE_W = WORDS * WORD_W;
   localparam int NWORDS = 1 << (ADDR_W - 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              req_wb = 1'b0, req_wt = 1'b0;
   logic              c_we = 1'b0;
   logic [ADDR_W-1:0] c_addr = '0;
   logic [WORD_W-1:0] c_wdata = '0;
   int                lat = 2;

   logic [WORD_W-1:0] rdata_wb, rdata_wt;
   logic              stall_wb, stall_wt;
   logic              mreq_wb, mreq_wt, mwe_wb, mwe_wt, mack_wb, mack_wt;
   logic [BA_W-1:0]   maddr_wb, maddr_wt;
   logic [LINE_W-1:0] mwd_wb, mwd_wt, mrd_wb, mrd_wt;
   int                wr_wb, wr_wt, rd_wb, rd_wt;

   dm_cache_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .WORDS(WORDS),
                   .WRITE_BACK(1'b1)) u_dm_cache_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(req_wb), .cpu_we(c_we), .cpu_addr(c_addr),
      .cpu_wdata(c_wdata), .cpu_rdata(rdata_wb), .cpu_stall(stall_wb),
      .mem_req(mreq_wb), .mem_we(mwe_wb), .mem_addr(maddr_wb), .mem_wdata(mwd_wb),
      .mem_rdata(mrd_wb), .mem_ack(mack_wb));

   dm_cache_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .WORDS(WORDS),
                   .WRITE_BACK(1'b0)) u_dm_cache_ctrl_wt (
      .clk(clk), .rst_n(rst_n), .cpu_req(req_wt), .cpu_we(c_we), .cpu_addr(c_addr),
      .cpu_wdata(c_wdata), .cpu_rdata(rdata_wt), .cpu_stall(stall_wt),
      .mem_req(mreq_wt), .mem_we(mwe_wt), .mem_addr(maddr_wt), .mem_wdata(mwd_wt),
      .mem_rdata(mrd_wt), .mem_ack(mack_wt));

   dmc_bench_mem #(.BA_W(BA_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_mem_wb (
      .clk(clk), .rst_n(rst_n), .lat(lat), .req(mreq_wb), .we(mwe_wb), .addr(maddr_wb),
      .wdata(mwd_wb), .rdata(mrd_wb), .ack(mack_wb), .wr_cnt(wr_wb), .rd_cnt(rd_wb));

   dmc_bench_mem #(.BA_W(BA_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_mem_wt (
      .clk(clk), .rst_n(rst_n), .lat(lat), .req(mreq_wt), .we(mwe_wt), .addr(maddr_wt),
      .wdata(mwd_wt), .rdata(mrd_wt), .ack(mack_wt), .wr_cnt(wr_wt), .rd_cnt(rd_wt));

   int checks = 0;
   int errors = 0;
   logic [WORD_W-1:0] gold [NWORDS];
   logic [WORD_W-1:0] res_wb, res_wt;
   int n_wb, n_wt;

   function automatic logic [WORD_W-1:0] seed_word(int i);
      return WORD_W'(i) * WORD_W'(32'h0001_0101) + WORD_W'(32'h5A00_0000);
   endfunction

   function automatic logic [WORD_W-1:0] mem_word_wb(int a);
      return u_mem_wb.mem[a >> 4][((a >> 2) % WORDS)*WORD_W +: WORD_W];
   endfunction

   function automatic logic [WORD_W-1:0] mem_word_wt(int a);
      return u_mem_wt.mem[a >> 4][((a >> 2) % WORDS)*WORD_W +: WORD_W];
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic access(input bit we, input int a, input logic [WORD_W-1:0] d);
      bit fin_wb = 1'b0, fin_wt = 1'b0;
      int n = 0;
      @(negedge clk);
      c_we = we; c_addr = ADDR_W'(a); c_wdata = d;
      req_wb = 1'b1; req_wt = 1'b1;
      while (req_wb || req_wt) begin
         #1;
         if (req_wb && !fin_wb && !stall_wb) begin res_wb = rdata_wb; n_wb = n; fin_wb = 1'b1; end
         if (req_wt && !fin_wt && !stall_wt) begin res_wt = rdata_wt; n_wt = n; fin_wt = 1'b1; end
         @(posedge clk); #1;
         if (fin_wb) req_wb = 1'b0;
         if (fin_wt) req_wt = 1'b0;
         n++;
         if (n > 2000) begin
            chk(1'b0, "R4", "access never completed", 64'(n), 64'd0);
            req_wb = 1'b0; req_wt = 1'b0;
         end
         if (req_wb || req_wt) @(negedge clk);
      end
      if (we) gold[a >> 2] = d;
   endtask

   task automatic read_both(input int a, input string rq);
      access(1'b0, a, '0);
      chk(res_wb == gold[a >> 2], rq, "write-back read data", 64'(res_wb), 64'(gold[a >> 2]));
      chk(res_wt == gold[a >> 2], rq, "write-through read data", 64'(res_wt), 64'(gold[a >> 2]));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      chk(1'b0, "R4", "watchdog expired", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int a;
      int wr0;
      logic [WORD_W-1:0] v;
      for (int i = 0; i < NWORDS; i++) gold[i] = seed_word(i);
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R2 idle ports after reset
      chk(!stall_wb && !stall_wt, "R2", "stall after reset", 64'({stall_wb, stall_wt}), 64'd0);
      chk(!mreq_wb && !mreq_wt, "R2", "mem_req after reset", 64'({mreq_wb, mreq_wt}), 64'd0);

      lat = 2;
      // R2 R5 cold read miss, clean victim: 3+L cycles
      read_both(12'h000, "R5");
      chk(n_wb == 5 && n_wt == 5, "R4", "cold miss stall", 64'({n_wb[15:0], n_wt[15:0]}), 64'h0005_0005);
      chk(wr_wb == 0 && wr_wt == 0, "R2", "no write-back after reset", 64'(wr_wb + wr_wt), 64'd0);
      chk(rd_wb == 1 && rd_wt == 1, "R5", "single block read", 64'(rd_wb + rd_wt), 64'd2);

      // R3 R5 rest of the block hits
      read_both(12'h004, "R3");
      chk(n_wb == 0 && n_wt == 0, "R3", "read hit stall", 64'(n_wb + n_wt), 64'd0);

      // R6 R9 write hit
      v = 32'hCAFE_0001;
      access(1'b1, 12'h008, v);
      chk(n_wb == 0, "R6", "write-back write hit stall", 64'(n_wb), 64'd0);
      chk(wr_wb == 0, "R6", "write-back write hit memory writes", 64'(wr_wb), 64'd0);
      chk(mem_word_wb(12'h008) == seed_word(2), "R6", "memory untouched", 64'(mem_word_wb(12'h008)), 64'(seed_word(2)));
      chk(n_wt == 5, "R9", "write-through write hit stall", 64'(n_wt), 64'd5);
      chk(wr_wt == 1, "R9", "write-through write count", 64'(wr_wt), 64'd1);
      chk(mem_word_wt(12'h008) == v, "R9", "write-through memory word", 64'(mem_word_wt(12'h008)), 64'(v));
      read_both(12'h008, "R3");
      chk(n_wb == 0 && n_wt == 0, "R3", "read-back hit stall", 64'(n_wb + n_wt), 64'd0);

      // R1 R7 conflicting tag evicts the dirty line: 5+2L
      read_both(12'h080, "R1");
      chk(n_wb == 9, "R7", "dirty eviction stall", 64'(n_wb), 64'd9);
      chk(wr_wb == 1, "R7", "dirty eviction write count", 64'(wr_wb), 64'd1);
      chk(mem_word_wb(12'h008) == v, "R7", "victim data in memory", 64'(mem_word_wb(12'h008)), 64'(v));
      chk(n_wt == 5 && wr_wt == 1, "R9", "no write-back in write-through", 64'(wr_wt), 64'd1);

      // R7 clean victim: no write
      read_both(12'h008, "R1");
      chk(n_wb == 5 && wr_wb == 1, "R7", "clean eviction writes", 64'(wr_wb), 64'd1);

      // R8 write miss allocates
      v = 32'hBEEF_0002;
      access(1'b1, 12'h114, v);
      chk(n_wb == 5 && wr_wb == 1, "R8", "write-back write miss", 64'({n_wb[15:0], wr_wb[15:0]}), 64'h0005_0001);
      chk(n_wt == 9 && wr_wt == 2, "R9", "write-through write miss", 64'({n_wt[15:0], wr_wt[15:0]}), 64'h0009_0002);
      read_both(12'h114, "R8");
      chk(n_wb == 0 && n_wt == 0, "R8", "allocated line hits", 64'(n_wb + n_wt), 64'd0);
      read_both(12'h110, "R8");
      chk(n_wb == 0 && n_wt == 0, "R8", "merged block neighbour hits", 64'(n_wb + n_wt), 64'd0);

      // R10 sweep over latencies, tags, lines and words
      for (int l = 0; l < 4; l++) begin
         lat = l;
         for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < LINES; i++) begin
               for (int w = 0; w < WORDS; w++) begin
                  a = (t << 7) | (i << 4) | (w << 2);
                  wr0 = wr_wt;
                  v = 32'hF00D_0000 + WORD_W'((l << 12) | (t << 8) | (i << 4) | w);
                  access(1'b1, a, v);
                  chk(wr_wt == wr0 + 1, "R9", "one write per write", 64'(wr_wt), 64'(wr0 + 1));
                  chk(mem_word_wt(a) == v, "R9", "write-through memory", 64'(mem_word_wt(a)), 64'(v));
                  if (w == 0 && t > 0) begin
                     for (int k = 0; k < WORDS; k++) begin
                        int pa;
                        pa = ((t - 1) << 7) | (i << 4) | (k << 2);
                        chk(mem_word_wb(pa) == gold[pa >> 2], "R7", "evicted block in memory",
                            64'(mem_word_wb(pa)), 64'(gold[pa >> 2]));
                     end
                  end
               end
               for (int w = 0; w < WORDS; w++) begin
                  a = (t << 7) | (i << 4) | (w << 2);
                  read_both(a, "R10");
               end
            end
         end
      end

      // R1 all lines of the last tag stay resident
      for (int i = 0; i < LINES; i++) begin
         for (int w = 0; w < WORDS; w++) begin
            a = (3 << 7) | (i << 4) | (w << 2);
            read_both(a, "R1");
            chk(n_wb == 0 && n_wt == 0, "R1", "distinct indices resident", 64'(n_wb + n_wt), 64'd0);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule